// File: doc/BRIEF.md
# SPI Interrupt and TX-Watermark Unit

This unit is the status and interrupt side of a byte-wide SPI controller. It takes the live transmit and receive FIFO fill levels and a mode-fault pulse from the serial engine. From these it builds a status word, and it drives one registered interrupt line to the processor. Software reaches it through a small word-addressed register port. That port gives access to the status word (write one to clear), to separate set-mask and clear-mask ports acting on a single readable mask, to a transmit watermark threshold, and to the head of the receive FIFO. A read of the receive FIFO head pops it.

The threshold register is exactly log2(FIFO_DEPTH) bits wide and drops any higher bits on a write. Software can therefore write all ones and read back the depth minus one. Sticky bits record events until software clears them. Level bits follow the FIFO state every cycle.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the status word and the mask read 0, the threshold reads 1 and `irq_o` is low.
- R2: A one-cycle pulse on `mode_fault_i` sets status bit 1 (mode fault) on the next clock edge, and the bit stays set until software clears it.
- R3: A write to register 0 (status) clears every status bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A set condition present in the same cycle wins over the clear.
- R4: A write to register 1 sets the mask bits given by write-data bits [6:0], and a write to register 2 clears them. Register 3 reads the 7-bit mask and ignores writes.
- R5: Register 4 (threshold) keeps only the low log2(FIFO_DEPTH) bits of a write, so writing 0xFFFF reads back FIFO_DEPTH-1.
- R6: Status bit 2 (TX over-watermark) is sticky. It is set on every clock edge at which `tx_level_i` is below the threshold.
- R7: Status bit 3 (TX full) equals (`tx_level_i` == FIFO_DEPTH) as sampled at the previous clock edge. It is not held once the condition ends.
- R8: Status bit 4 (RX not empty) equals (`rx_level_i` != 0) as sampled at the previous clock edge. A read of register 5 returns `rx_data_i` and raises `rx_pop_o` for that cycle only.
- R9: `irq_o` is a register. It goes high on the clock edge after any status bit and its mask bit are both set, and it falls on the edge after that condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| tx_level_i | input | 5 | Transmit FIFO fill level |
| rx_level_i | input | 5 | Receive FIFO fill level |
| rx_data_i | input | 8 | Head entry of the receive FIFO |
| mode_fault_i | input | 1 | Mode-fault event pulse from the engine |
| rx_pop_o | output | 1 | Pops the receive FIFO |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same cycle as a new set condition. Software alone cannot line these up. The bench holds `mode_fault_i` high through the exact clock edge of a write-one-to-clear and then reads the bit back. It does the same for the over-watermark bit by keeping the transmit level below the threshold during the clear. The one-edge lag of `irq_o` behind the status word is checked on both its rising and falling edges, with the bench sampling between edges.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int STAT_W = 7;

  localparam int BIT_MODF   = 1;
  localparam int BIT_TXOW   = 2;
  localparam int BIT_TXFULL = 3;
  localparam int BIT_RXNE   = 4;

  // which status bits hold until cleared, and which follow live state
  localparam logic [STAT_W-1:0] STICKY_BITS = 7'b000_0110;
  localparam logic [STAT_W-1:0] LIVE_BITS   = 7'b001_1000;

  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_IEN   = 3'd1,
    REG_IDIS  = 3'd2,
    REG_IMASK = 3'd3,
    REG_THR   = 3'd4,
    REG_RXD   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/spi_irq_thresh.sv
module spi_irq_thresh #(
  parameter int THR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [THR_W-1:0] wdata_i,
  output logic [THR_W-1:0] thr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   thr_o <= THR_W'(1);
    else if (wr_i) thr_o <= wdata_i;
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = 5,
  parameter int THR_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              mode_fault_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] cond;

  always_comb begin
    cond             = '0;
    cond[BIT_MODF]   = mode_fault_i;
    cond[BIT_TXOW]   = tx_level_i < LVL_W'(thr_i);
    cond[BIT_TXFULL] = tx_level_i == LVL_W'(FIFO_DEPTH);
    cond[BIT_RXNE]   = rx_level_i != '0;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (STICKY_BITS[i]) begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       stat_o[i] <= 1'b0;
        else if (cond[i])  stat_o[i] <= 1'b1;  // set beats clear
        else if (clr_i[i]) stat_o[i] <= 1'b0;
      end
    end else if (LIVE_BITS[i]) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_o[i] <= 1'b0;
        else         stat_o[i] <= cond[i];
      end
    end else begin : g_rsvd
      assign stat_o[i] = 1'b0;
    end
  end

  logic unused_clr;
  assign unused_clr = ^(clr_i & ~STICKY_BITS);
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_wr_i,
  input  logic              dis_wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_o <= '0;
    else if (en_wr_i)  mask_o <= mask_o | wdata_i;
    else if (dis_wr_i) mask_o <= mask_o & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_i & mask_o);
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 16,
  parameter int RXD_W      = 8,
  localparam int THR_W     = $clog2(FIFO_DEPTH),
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [RXD_W-1:0]  rx_data_i,
  input  logic              mode_fault_i,
  output logic              rx_pop_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, mask_q, clr_vec;
  logic [THR_W-1:0]  thr_q;
  logic              wr_stat, wr_en, wr_dis, wr_thr;

  assign wr_stat = reg_wr_i && reg_addr_i == REG_STAT;
  assign wr_en   = reg_wr_i && reg_addr_i == REG_IEN;
  assign wr_dis  = reg_wr_i && reg_addr_i == REG_IDIS;
  assign wr_thr  = reg_wr_i && reg_addr_i == REG_THR;
  assign clr_vec = wr_stat ? reg_wdata_i[STAT_W-1:0] : '0;

  spi_irq_thresh #(.THR_W(THR_W)) u_thr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_thr),
    .wdata_i (reg_wdata_i[THR_W-1:0]),
    .thr_o   (thr_q)
  );

  spi_irq_status #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W),
    .THR_W      (THR_W)
  ) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr_vec),
    .mode_fault_i (mode_fault_i),
    .tx_level_i   (tx_level_i),
    .rx_level_i   (rx_level_i),
    .thr_i        (thr_q),
    .stat_o       (stat_q)
  );

  spi_irq_mask u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_wr_i  (wr_en),
    .dis_wr_i (wr_dis),
    .wdata_i  (reg_wdata_i[STAT_W-1:0]),
    .stat_i   (stat_q),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_STAT:  reg_rdata_o = DATA_W'(stat_q);
      REG_IMASK: reg_rdata_o = DATA_W'(mask_q);
      REG_THR:   reg_rdata_o = DATA_W'(thr_q);
      REG_RXD:   reg_rdata_o = DATA_W'(rx_data_i);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign rx_pop_o = reg_rd_i && reg_addr_i == REG_RXD;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;
endmodule

// File: rtl/spi_irq_unit_chk.sv
module spi_irq_unit_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 16,
  parameter int LVL_W      = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              mode_fault_i,
  input logic [LVL_W-1:0]  tx_level_i,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic [6:0]        stat_q,
  input logic [6:0]        mask_q,
  input logic              irq_o
);
  AST_MODF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_fault_i |=> stat_q[1]); // R2
  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd0 && reg_wdata_i[1] && !mode_fault_i) |=> !stat_q[1]); // R3
  AST_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[1] && !(reg_wr_i && reg_addr_i == 3'd0 && reg_wdata_i[1])) |=> stat_q[1]); // R3
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd1) |=> ((mask_q & $past(reg_wdata_i[6:0])) == $past(reg_wdata_i[6:0]))); // R4
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd2) |=> ((mask_q & $past(reg_wdata_i[6:0])) == 7'd0)); // R4
  AST_TXFULL_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stat_q[3] == ($past(tx_level_i) == LVL_W'(FIFO_DEPTH))); // R7
  AST_RXNE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stat_q[4] == ($past(rx_level_i) != '0)); // R8
  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(stat_q & mask_q))); // R9
endmodule

bind spi_irq_unit spi_irq_unit_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .DATA_W     (DATA_W),
  .LVL_W      (LVL_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .mode_fault_i (mode_fault_i),
  .tx_level_i   (tx_level_i),
  .rx_level_i   (rx_level_i),
  .stat_q       (stat_q),
  .mask_q       (mask_q),
  .irq_o        (irq_o)
);

// File: tb/sim_spi_irq_unit.sv
`timescale 1ns/1ps
module sim_spi_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [4:0]  tx_level = 5'd4, rx_level = 5'd0;
  logic [7:0]  rx_data = 8'h00;
  logic        mode_fault = 1'b0;
  logic        rx_pop, irq;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_level_i(tx_level), .rx_level_i(rx_level), .rx_data_i(rx_data),
    .mode_fault_i(mode_fault), .rx_pop_o(rx_pop), .irq_o(irq)
  );

  // {tx_level, rx_level, threshold, expected status[4:1] = rxne,full,txow,modf}
  localparam logic [17:0] VEC [6] = '{
    {5'd4,  5'd0,  4'd1,  4'b0000},
    {5'd0,  5'd3,  4'd1,  4'b1010},
    {5'd16, 5'd16, 4'd15, 4'b1100},
    {5'd7,  5'd0,  4'd8,  4'b0010},
    {5'd8,  5'd1,  4'd8,  4'b1000},
    {5'd15, 5'd0,  4'd15, 4'b0000}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d, output logic pop);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata; pop = rx_pop;
    @(posedge clk); #1 reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic        p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq == 1'b0, "R1 irq", 16'(irq), 16'h0);
    rd_reg(3'd0, d, p); check(d == 16'h0, "R1 status", d, 16'h0);
    rd_reg(3'd3, d, p); check(d == 16'h0, "R1 mask", d, 16'h0);
    rd_reg(3'd4, d, p); check(d == 16'h1, "R1 threshold", d, 16'h1);

    // R5 threshold truncation
    wr_reg(3'd4, 16'hFFFF);
    rd_reg(3'd4, d, p); check(d == 16'd15, "R5 truncate", d, 16'd15);
    wr_reg(3'd4, 16'h0013);
    rd_reg(3'd4, d, p); check(d == 16'd3, "R5 low bits kept", d, 16'd3);

    // table: R6 R7 R8 status under level patterns
    foreach (VEC[i]) begin
      tx_level = VEC[i][17:13];
      rx_level = VEC[i][12:8];
      wr_reg(3'd4, 16'(VEC[i][7:4]));
      wr_reg(3'd0, 16'h007F);
      rd_reg(3'd0, d, p);
      check(d == {11'd0, VEC[i][3:0], 1'b0}, "R6/R7/R8 table", d, {11'd0, VEC[i][3:0], 1'b0});
    end

    // quiet levels for the directed part
    tx_level = 5'd4; rx_level = 5'd0;
    wr_reg(3'd4, 16'd1);
    wr_reg(3'd0, 16'h007F);

    // R6 sticky: over-watermark stays after the level recovers, clears by W1C
    tx_level = 5'd0; @(negedge clk); tx_level = 5'd4; @(negedge clk);
    rd_reg(3'd0, d, p); check(d[2] == 1'b1, "R6 sticky txow", d, 16'h0004);
    wr_reg(3'd0, 16'h0004);
    rd_reg(3'd0, d, p); check(d[2] == 1'b0, "R6 txow cleared", d, 16'h0000);

    // R2 mode fault pulse
    mode_fault = 1'b1; @(posedge clk); #1 mode_fault = 1'b0; @(negedge clk);
    repeat (3) @(negedge clk);
    rd_reg(3'd0, d, p); check(d == 16'h0002, "R2 modf sticky", d, 16'h0002);
    // R3 writing zeros leaves it
    wr_reg(3'd0, 16'h0000);
    rd_reg(3'd0, d, p); check(d == 16'h0002, "R3 write0 keeps", d, 16'h0002);
    // R3 set wins over clear in same cycle
    mode_fault = 1'b1; wr_reg(3'd0, 16'h0002); mode_fault = 1'b0;
    rd_reg(3'd0, d, p); check(d == 16'h0002, "R3 set beats clear", d, 16'h0002);
    wr_reg(3'd0, 16'h0002);
    rd_reg(3'd0, d, p); check(d == 16'h0000, "R3 write1 clears", d, 16'h0000);

    // R4 mask set / clear / direct write ignored
    wr_reg(3'd1, 16'h0012);
    rd_reg(3'd3, d, p); check(d == 16'h0012, "R4 enable", d, 16'h0012);
    wr_reg(3'd1, 16'h0004);
    rd_reg(3'd3, d, p); check(d == 16'h0016, "R4 enable accumulates", d, 16'h0016);
    wr_reg(3'd2, 16'h0010);
    rd_reg(3'd3, d, p); check(d == 16'h0006, "R4 disable", d, 16'h0006);
    wr_reg(3'd3, 16'h007F);
    rd_reg(3'd3, d, p); check(d == 16'h0006, "R4 mask not writable", d, 16'h0006);
    wr_reg(3'd1, 16'hFFFF);
    rd_reg(3'd3, d, p); check(d == 16'h007F, "R4 seven bits", d, 16'h007F);
    wr_reg(3'd2, 16'h007D);
    rd_reg(3'd3, d, p); check(d == 16'h0002, "R4 only modf left", d, 16'h0002);

    // R9 irq lags status by one edge
    check(irq == 1'b0, "R9 idle", 16'(irq), 16'h0);
    mode_fault = 1'b1; @(posedge clk); #1 mode_fault = 1'b0; @(negedge clk);
    check(irq == 1'b0, "R9 one edge lag", 16'(irq), 16'h0);
    @(negedge clk);
    check(irq == 1'b1, "R9 raised", 16'(irq), 16'h1);
    wr_reg(3'd0, 16'h0002);
    check(irq == 1'b1, "R9 fall lag", 16'(irq), 16'h1);
    @(negedge clk);
    check(irq == 1'b0, "R9 fallen", 16'(irq), 16'h0);
    // masked-off bit raises nothing
    wr_reg(3'd2, 16'h0002);
    mode_fault = 1'b1; @(posedge clk); #1 mode_fault = 1'b0;
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R9 masked", 16'(irq), 16'h0);
    wr_reg(3'd0, 16'h0002);

    // R8 receive data read pops once
    rx_data = 8'hA5; rx_level = 5'd2; @(negedge clk);
    rd_reg(3'd5, d, p);
    check(d == 16'h00A5, "R8 rx data", d, 16'h00A5);
    check(p == 1'b1, "R8 pop on read", 16'(p), 16'h1);
    check(rx_pop == 1'b0, "R8 pop one cycle", 16'(rx_pop), 16'h0);
    rd_reg(3'd0, d, p);
    check(d[4] == 1'b1 && p == 1'b0, "R8 rxne set, no pop", d, 16'h0010);
    rx_level = 5'd0; @(negedge clk);
    rd_reg(3'd0, d, p); check(d[4] == 1'b0, "R8 rxne follows level", d, 16'h0000);

    finish_run();
  end
endmodule